// File: doc/BRIEF.md
# Serial Controller Command Decode and External Status Latch

This block sits behind the command register of a two-channel serial communications controller. Each byte the CPU writes to the command register has three parts. The low three bits are a register pointer. The middle three bits are a command code. The top two bits are a second reset code. The block turns the byte into a register address for the next access, and into single-cycle command strobes for the shifters, CRC engines and interrupt logic that sit around it. One of the command codes lifts the pointer into the upper bank of eight registers, and this applies to a single access only.

The block also holds a frozen copy of the external status inputs (modem lines, break) together with the transmit underrun/end-of-message flag. Any change to these inputs is latched and raises an interrupt request. The latched value is held until the CPU issues the status-reset command. A further change that arrives while the latch is held is stored in a one-deep queue and is presented once the latch is released. The underrun/end-of-message flag is set when CRC transmission starts. Its reset command clears it only while the transmitter is enabled. While the transmitter is disabled, the same command instead forces a status event that reports the flag as clear.

Top module: `sercmd_stat`

## Requirements
- R1: On a write with command code (bits 5:3) 000, `reg_addr` becomes {0, bits 2:0} after the clock edge that takes the write, and no strobe fires.
- R2: A write with command code 001 makes `reg_addr` equal to bits 2:0 plus eight. The value holds until the next register access.
- R3: After a `reg_access` pulse while `reg_addr` is non-zero, `reg_addr` returns to 0. An access while `reg_addr` is 0 leaves it at 0.
- R4: Command codes 011, 100, 101, 110 and 111 each pulse `cmd_strb` bit (code minus 3) for exactly one cycle, on the edge after the write. Codes 000, 001 and 010 pulse no strobe.
- R5: Bits 7:6 of the byte give a second reset code. 01 pulses `cmd_strb[5]` (receive CRC reset) and 10 pulses `cmd_strb[6]` (transmit CRC reset). These pulses can fire in the same cycle as a strobe from R4.
- R6: `stat_q` is {eom flag, external inputs}. When this value changes while no event is pending, `stat_q` takes the new value and the event becomes pending on the next edge.
- R7: While an event is pending, `stat_q` holds still even if the inputs pulse.
- R8: Command code 010 clears the pending event, so `ext_irq` drops on the edge that takes the write. If a change arrived while the event was pending, the most recent such value is loaded into `stat_q`, and `ext_irq` rises again one cycle later.
- R9: `ext_irq` is high exactly when an event is pending and `ext_ie` is high. A masked event stays pending.
- R10: `crc_start` sets `tx_eom` on the next edge. Reset code 11 clears `tx_eom` when `tx_en` is high.
- R11: While `tx_en` is low, reset code 11 leaves `tx_eom` set. If no event is pending, or if code 010 comes in the same byte, it forces a pending event with `stat_q` = {0, external inputs}. If an event is pending and code 010 is absent, it has no effect.
- R12: During reset, `reg_addr` is 0, `cmd_strb` is 0, `ext_irq` is 0, `tx_eom` is 0, and `stat_q` is {0, external inputs}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command byte |
| reg_access | input | 1 | CPU accessed the register at `reg_addr` |
| reg_addr | output | 4 | Register selected for the next access |
| cmd_strb | output | 7 | One-cycle strobes: 0 abort, 1 rx-next int enable, 2 tx int reset, 3 error reset, 4 IUS reset, 5 rx CRC reset, 6 tx CRC reset |
| ext_in | input | N_EXT | External status inputs, already synchronised |
| crc_start | input | 1 | Transmitter begins sending CRC |
| tx_en | input | 1 | Transmitter enabled |
| ext_ie | input | 1 | External/status interrupt enable |
| ext_irq | output | 1 | External/status interrupt request |
| stat_q | output | N_EXT+1 | Latched status: MSB is the reported eom flag |
| tx_eom | output | 1 | Live underrun/end-of-message flag |

## Verification
The hardest situation to reach is a forced underrun event while the transmitter is disabled and a change is already pending. In that case the eom reset byte must also carry the status-reset code. Once it does, the frozen value differs from the live flag, so a queued change builds up behind the forced event. The stimulus first sets the flag through `crc_start` with `tx_en` low and lets that change latch. It then writes the eom reset alone, to show that nothing happens. Next it writes the combined byte, waits one cycle so the live flag is queued, and issues status resets one after another to watch the queued value come out and the interrupt fall, rise and fall again.

// File: rtl/sercmd_pkg.sv
`timescale 1ns/1ps
// Package: shared codes and decoded-command type for the command/status block.
// Assumes an 8-bit command byte: pointer in bits 2:0, command code in 5:3,
// second reset code in 7:6.
package sercmd_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 3;
    localparam int STRB_W   = 7;
    localparam int CODE_STRB_BASE = 3;  // first command code that maps to a strobe
    localparam int N_CODE_STRB    = 5;  // codes 3..7 map to strobes 0..4

    typedef enum logic [2:0] {
        CMD_NULL     = 3'd0,
        CMD_PTR_HI   = 3'd1,
        CMD_STAT_RST = 3'd2,
        CMD_ABORT    = 3'd3,
        CMD_RXNEXT   = 3'd4,
        CMD_TXIP_RST = 3'd5,
        CMD_ERR_RST  = 3'd6,
        CMD_IUS_RST  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        RST_NONE  = 2'd0,
        RST_RXCRC = 2'd1,
        RST_TXCRC = 2'd2,
        RST_EOM   = 2'd3
    } rst_e;

    typedef struct packed {
        logic             ptr_hi;
        logic             stat_rst;
        logic             eom_rst;
        logic [PTR_W-1:0] ptr;
    } dec_t;

endpackage

// File: rtl/sercmd_decode.sv
`timescale 1ns/1ps
// Module: sercmd_decode
// Splits a command byte into same-cycle control fields (pointer, point-high,
// status reset, eom reset) and registered one-cycle command strobes.
// Assumes wr_en is high for one cycle per CPU write.
module sercmd_decode
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output dec_t              dec,
    output logic [STRB_W-1:0] strb
);

    cmd_e              code;
    rst_e              rcode;
    logic [STRB_W-1:0] strb_nxt;

    // Field extraction of the command byte.
    always_comb begin
        code  = cmd_e'(wr_data[5:3]);
        rcode = rst_e'(wr_data[7:6]);
    end

    // Same-cycle decoded controls consumed by pointer, latch and eom logic.
    always_comb begin
        dec.ptr      = wr_data[PTR_W-1:0];
        dec.ptr_hi   = wr_en && (code == CMD_PTR_HI);
        dec.stat_rst = wr_en && (code == CMD_STAT_RST);
        dec.eom_rst  = wr_en && (rcode == RST_EOM);
    end

    // One strobe bit per command code 3..7.
    genvar gi;
    generate
        for (gi = 0; gi < N_CODE_STRB; gi++) begin : g_code_strb
            always_comb strb_nxt[gi] = wr_en && (wr_data[5:3] == 3'(gi + CODE_STRB_BASE));
        end
    endgenerate

    // Strobes from the second reset code.
    always_comb begin
        strb_nxt[N_CODE_STRB]     = wr_en && (rcode == RST_RXCRC);
        strb_nxt[N_CODE_STRB + 1] = wr_en && (rcode == RST_TXCRC);
    end

    // Register strobes so each pulses on the edge after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) strb <= '0;
        else        strb <= strb_nxt;
    end

endmodule

// File: rtl/sercmd_ptr.sv
`timescale 1ns/1ps
// Module: sercmd_ptr
// Holds the register pointer. Point-high lifts the address by eight for one
// access; any access to a non-zero register returns the pointer to zero.
// Assumes a write and an access in the same cycle let the write win.
module sercmd_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic             ptr_hi,
    input  logic             reg_access,
    output logic [PTR_W:0]   reg_addr
);

    logic [PTR_W-1:0] ptr_q;
    logic             hi_q;

    // Load on write, clear after an access to a non-zero register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            hi_q  <= 1'b0;
        end else if (wr_en) begin
            ptr_q <= ptr_in;
            hi_q  <= ptr_hi;
        end else if (reg_access && (hi_q || (ptr_q != '0))) begin
            ptr_q <= '0;
            hi_q  <= 1'b0;
        end
    end

    // Upper bank bit sits above the pointer field.
    always_comb reg_addr = {hi_q, ptr_q};

endmodule

// File: rtl/sercmd_eom.sv
`timescale 1ns/1ps
// Module: sercmd_eom
// Transmit underrun/end-of-message flag. Set by CRC start; cleared by the eom
// reset code only while the transmitter is enabled. When disabled, the reset
// code is turned into a force request for the status latch.
// Assumes set wins over a same-cycle clear.
module sercmd_eom (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_start,
    input  logic tx_en,
    input  logic eom_rst,
    output logic eom_q,
    output logic force_req
);

    // Flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 eom_q <= 1'b0;
        else if (crc_start)         eom_q <= 1'b1;
        else if (eom_rst && tx_en)  eom_q <= 1'b0;
    end

    // Disabled-transmitter reset becomes a status event request.
    always_comb force_req = eom_rst && !tx_en;

endmodule

// File: rtl/sercmd_extlatch.sv
`timescale 1ns/1ps
// Module: sercmd_extlatch
// Latches the status vector on change and freezes it while pending, with a
// one-deep queue for changes seen while frozen. A status reset releases the
// latch; a queued value is loaded and the event re-pends one cycle later.
// Assumes src inputs are synchronous to clk.
module sercmd_extlatch #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr_val,
    input  logic         stat_rst,
    input  logic         force_req,
    output logic [W-1:0] lat_q,
    output logic         pend_q
);

    logic [W-1:0] que_q;
    logic         que_v;
    logic         rearm_q;
    logic         force_ev;

    // A forced event happens if nothing is pending or a reset comes with it.
    always_comb force_ev = force_req && (!pend_q || stat_rst);

    // Latch, queue and pending state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q   <= clr_val;
            pend_q  <= 1'b0;
            que_q   <= '0;
            que_v   <= 1'b0;
            rearm_q <= 1'b0;
        end else if (force_ev) begin
            lat_q   <= clr_val;
            pend_q  <= 1'b1;
            que_v   <= 1'b0;
            rearm_q <= 1'b0;
        end else if (stat_rst) begin
            pend_q <= 1'b0;
            if (que_v) begin
                lat_q   <= que_q;
                que_v   <= 1'b0;
                rearm_q <= 1'b1;
            end else begin
                rearm_q <= 1'b0;
            end
        end else if (rearm_q) begin
            pend_q  <= 1'b1;
            rearm_q <= 1'b0;
        end else if (!pend_q) begin
            if (src != lat_q) begin
                lat_q  <= src;
                pend_q <= 1'b1;
            end
        end else if (src != lat_q) begin
            que_q <= src;
            que_v <= 1'b1;
        end
    end

endmodule

// File: rtl/sercmd_stat.sv
`timescale 1ns/1ps
// Module: sercmd_stat (top)
// Command register decode plus external status latch and underrun/EOM flag
// for one serial channel. Assumes all inputs synchronous to clk.
module sercmd_stat
    import sercmd_pkg::*;
#(
    parameter int N_EXT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             reg_access,
    output logic [3:0]       reg_addr,
    output logic [6:0]       cmd_strb,
    input  logic [N_EXT-1:0] ext_in,
    input  logic             crc_start,
    input  logic             tx_en,
    input  logic             ext_ie,
    output logic             ext_irq,
    output logic [N_EXT:0]   stat_q,
    output logic             tx_eom
);

    localparam int SW = N_EXT + 1;

    dec_t          dec;
    logic          force_req;
    logic          pend;
    logic [SW-1:0] src;
    logic [SW-1:0] clr_val;

    sercmd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dec     (dec),
        .strb    (cmd_strb)
    );

    sercmd_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .ptr_in     (dec.ptr),
        .ptr_hi     (dec.ptr_hi),
        .reg_access (reg_access),
        .reg_addr   (reg_addr)
    );

    sercmd_eom u_eom (
        .clk       (clk),
        .rst_n     (rst_n),
        .crc_start (crc_start),
        .tx_en     (tx_en),
        .eom_rst   (dec.eom_rst),
        .eom_q     (tx_eom),
        .force_req (force_req)
    );

    // Status vector sources: live flag above the external inputs.
    always_comb begin
        src     = {tx_eom, ext_in};
        clr_val = {1'b0, ext_in};
    end

    sercmd_extlatch #(.W(SW)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .clr_val   (clr_val),
        .stat_rst  (dec.stat_rst),
        .force_req (force_req),
        .lat_q     (stat_q),
        .pend_q    (pend)
    );

    // Request gated by the enable.
    always_comb ext_irq = pend && ext_ie;

endmodule

// File: rtl/sercmd_stat_chk.sv
`timescale 1ns/1ps
// Module: sercmd_stat_chk
// Port-level properties of sercmd_stat, bound into every instance.
module sercmd_stat_chk #(
    parameter int N_EXT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [3:0]       reg_addr,
    input logic [6:0]       cmd_strb,
    input logic             crc_start,
    input logic             tx_en,
    input logic             ext_ie,
    input logic             ext_irq,
    input logic [N_EXT:0]   stat_q,
    input logic             tx_eom
);

    logic past_ok;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_STRB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (cmd_strb != '0)) |-> $past(wr_en)); // R4

    AST_CODE_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strb[4:0])); // R4

    AST_PTR_HI_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && ($past(wr_data[5:3]) == 3'b001)) |-> reg_addr[3]); // R2

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> ext_ie); // R9

    AST_STAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ext_irq && $past(ext_irq) && !$past(wr_en)) |-> $stable(stat_q)); // R7

    AST_RST_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && ($past(wr_data[5:3]) == 3'b010)
         && !(($past(wr_data[7:6]) == 2'b11) && !$past(tx_en))) |-> !ext_irq); // R8

    AST_EOM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(crc_start)) |-> tx_eom); // R10

    AST_EOM_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(tx_eom) && !$past(tx_en)) |-> tx_eom); // R11

endmodule

bind sercmd_stat sercmd_stat_chk #(.N_EXT(N_EXT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .reg_addr  (reg_addr),
    .cmd_strb  (cmd_strb),
    .crc_start (crc_start),
    .tx_en     (tx_en),
    .ext_ie    (ext_ie),
    .ext_irq   (ext_irq),
    .stat_q    (stat_q),
    .tx_eom    (tx_eom)
);

// File: tb/sercmd_stat_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected values per clock edge, the
// monitor pops and compares them shortly after each rising edge.
module sercmd_stat_tb_top;

    localparam int N_EXT = 5;
    localparam int SEL_ADDR = 0, SEL_STRB = 1, SEL_IRQ = 2, SEL_STAT = 3, SEL_EOM = 4;

    logic             clk = 1'b0;
    logic             rst_n, wr_en, reg_access, crc_start, tx_en, ext_ie;
    logic [7:0]       wr_data;
    logic [3:0]       reg_addr;
    logic [6:0]       cmd_strb;
    logic [N_EXT-1:0] ext_in;
    logic             ext_irq, tx_eom;
    logic [N_EXT:0]   stat_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        int          sel;
        int unsigned val;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    sercmd_stat #(.N_EXT(N_EXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .reg_access(reg_access), .reg_addr(reg_addr), .cmd_strb(cmd_strb),
        .ext_in(ext_in), .crc_start(crc_start), .tx_en(tx_en), .ext_ie(ext_ie),
        .ext_irq(ext_irq), .stat_q(stat_q), .tx_eom(tx_eom)
    );

    function automatic int unsigned pick(int sel);
        case (sel)
            SEL_ADDR: return 32'(reg_addr);
            SEL_STRB: return 32'(cmd_strb);
            SEL_IRQ:  return 32'(ext_irq);
            SEL_STAT: return 32'(stat_q);
            default:  return 32'(tx_eom);
        endcase
    endfunction

    function automatic void expect_v(string req, int sel, int unsigned val);
        item_t it;
        it.req = req; it.sel = sel; it.val = val;
        sb.push_back(it);
    endfunction

    // Monitor: compare queued expectations after each rising edge.
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            int unsigned act;
            it  = sb.pop_front();
            act = pick(it.sel);
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.val);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc();
        @(negedge clk);
        wr_en = 1'b0; reg_access = 1'b0; crc_start = 1'b0;
    endtask

    task automatic put(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; reg_access = 1'b0;
        crc_start = 1'b0; tx_en = 1'b1; ext_ie = 1'b1; ext_in = '0;
        repeat (3) @(negedge clk);
        expect_v("R12", SEL_ADDR, 0); expect_v("R12", SEL_STRB, 0);
        expect_v("R12", SEL_IRQ, 0);  expect_v("R12", SEL_STAT, 0);
        expect_v("R12", SEL_EOM, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Pointer and access (R1, R3)
        cyc(); put(8'h05); expect_v("R1", SEL_ADDR, 5); expect_v("R1", SEL_STRB, 0);
        cyc(); reg_access = 1'b1; expect_v("R3", SEL_ADDR, 0);
        cyc(); reg_access = 1'b1; expect_v("R3", SEL_ADDR, 0);
        // Point high (R2)
        cyc(); put(8'h0B); expect_v("R2", SEL_ADDR, 11); expect_v("R2", SEL_STRB, 0);
        cyc(); expect_v("R2", SEL_ADDR, 11);
        cyc(); reg_access = 1'b1; expect_v("R2", SEL_ADDR, 0);
        // Command strobes (R4)
        for (int c = 3; c < 8; c++) begin
            cyc(); put(8'(c << 3)); expect_v("R4", SEL_STRB, 32'(1 << (c - 3)));
            cyc(); expect_v("R4", SEL_STRB, 0);
        end
        cyc(); put(8'h10); expect_v("R4", SEL_STRB, 0); expect_v("R8", SEL_IRQ, 0);
        // Second reset code (R5)
        cyc(); put(8'h40); expect_v("R5", SEL_STRB, 32'h20);
        cyc(); put(8'h80); expect_v("R5", SEL_STRB, 32'h40);
        cyc(); put(8'h98); expect_v("R5", SEL_STRB, 32'h41);
        cyc(); expect_v("R4", SEL_STRB, 0);

        // Status latch, freeze and queue (R6, R7, R8)
        cyc(); ext_in = 5'b00001; expect_v("R6", SEL_STAT, 1); expect_v("R6", SEL_IRQ, 1);
        cyc(); ext_in = 5'b00011; expect_v("R7", SEL_STAT, 1); expect_v("R7", SEL_IRQ, 1);
        cyc(); ext_in = 5'b00001; expect_v("R7", SEL_STAT, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0); expect_v("R8", SEL_STAT, 3);
        cyc(); expect_v("R8", SEL_IRQ, 1); expect_v("R8", SEL_STAT, 3);
        cyc(); expect_v("R7", SEL_STAT, 3); expect_v("R7", SEL_IRQ, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0); expect_v("R8", SEL_STAT, 1);
        cyc(); expect_v("R8", SEL_IRQ, 1); expect_v("R8", SEL_STAT, 1);
        cyc(); expect_v("R8", SEL_STAT, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0);
        cyc(); expect_v("R8", SEL_IRQ, 0); expect_v("R8", SEL_STAT, 1);

        // Enable masking (R9)
        cyc(); ext_ie = 1'b0; ext_in = 5'b00101;
        expect_v("R9", SEL_IRQ, 0); expect_v("R9", SEL_STAT, 5);
        cyc(); ext_ie = 1'b1; expect_v("R9", SEL_IRQ, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0);
        cyc(); expect_v("R8", SEL_IRQ, 0); expect_v("R8", SEL_STAT, 5);

        // EOM flag with transmitter enabled (R10, R6)
        cyc(); crc_start = 1'b1; expect_v("R10", SEL_EOM, 1);
        cyc(); expect_v("R6", SEL_STAT, 32'h25); expect_v("R6", SEL_IRQ, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0);
        cyc(); put(8'hC0); expect_v("R10", SEL_EOM, 0);
        cyc(); expect_v("R6", SEL_STAT, 32'h05); expect_v("R6", SEL_IRQ, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0);

        // EOM flag with transmitter disabled (R11)
        cyc(); tx_en = 1'b0; crc_start = 1'b1; expect_v("R10", SEL_EOM, 1);
        cyc(); expect_v("R6", SEL_STAT, 32'h25); expect_v("R6", SEL_IRQ, 1);
        cyc(); put(8'hC0); expect_v("R11", SEL_EOM, 1);
        expect_v("R11", SEL_STAT, 32'h25); expect_v("R11", SEL_IRQ, 1);
        cyc(); put(8'hD0); expect_v("R11", SEL_EOM, 1);
        expect_v("R11", SEL_STAT, 32'h05); expect_v("R11", SEL_IRQ, 1);
        cyc(); expect_v("R11", SEL_STAT, 32'h05);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0); expect_v("R8", SEL_STAT, 32'h25);
        cyc(); expect_v("R8", SEL_IRQ, 1); expect_v("R8", SEL_STAT, 32'h25);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0);
        cyc(); expect_v("R8", SEL_IRQ, 0); expect_v("R8", SEL_STAT, 32'h25);
        cyc(); put(8'hC0); expect_v("R11", SEL_EOM, 1);
        expect_v("R11", SEL_STAT, 32'h05); expect_v("R11", SEL_IRQ, 1);
        cyc(); put(8'h10); expect_v("R8", SEL_IRQ, 0);
        cyc(); expect_v("R6", SEL_STAT, 32'h25); expect_v("R6", SEL_IRQ, 1);
        cyc();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule